// File: doc/BRIEF.md
# Radix-8 Booth Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns the full 2N-bit signed product. The multiplier operand (`mlr_i`) is recoded three bits at a time into signed digits in the range -4..+4, so an N-bit multiplier produces only ceil(N/3) partial products instead of N. Each digit selects one multiple of the multiplicand (`mcd_i`) from the set {0, 1, 2, 3, 4}, and may negate it. The 1, 2 and 4 multiples are plain wiring and left shifts. The 3 multiple comes from one shared pre-adder.

Partial products are formed at the full product width, so they are sign-extended, and shifted into position. A plain binary adder tree sums them, together with one correction word that carries the +1 of every negated digit. With `OUT_REG_EN=1`, the sum is captured in an output register on the clock. With `OUT_REG_EN=0`, the product is purely combinational and the clock and reset are unused. The block has no state machine: its only state is the optional output register.

Top module: `booth8_mul`

## Requirements
- R1: `prod_o` equals the signed product of `mcd_i` and `mlr_i`, both read as two's-complement, over the full 2N bits for every operand pair.
- R2: The multiplier is sign-extended to 3G bits, where G = ceil(N/3). It is split into G overlapping windows. Window i is {bit 3i+2, bit 3i+1, bit 3i, bit 3i-1}, and a 0 stands below bit 0. The digits, weighted by 8^i, sum to the sign-extended multiplier.
- R3: A window {w3,w2,w1,w0} maps to the digit -4*w3 + 2*w2 + w1 + w0. As a result, a 3-bit group value of 5, 6 or 7 becomes -3, -2 or -1, with +1 passed to the next group. Windows 0000 and 1111 give a positive zero digit.
- R4: The triple multiple equals 3 times the sign-extended multiplicand. It is formed once, by adding the doubled multiplicand to the multiplicand.
- R5: A negative digit yields the bitwise inverse of the selected multiple, shifted left by 3i. A 1 is added at bit 3i through the correction word. A zero digit yields an all-zero partial product.
- R6: If either operand is zero, the product is zero.
- R7: The most negative value times the most negative value gives 2^(2N-2), with no overflow into the sign bit.
- R8: With `OUT_REG_EN=1`, `prod_o` shows the product of the operands sampled at the previous rising clock edge. While `rst_ni` is low, `prod_o` is 0.
- R9: With `OUT_REG_EN=0`, `prod_o` follows the operands combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| mcd_i | input | N | Multiplicand, two's-complement |
| mlr_i | input | N | Multiplier, two's-complement, Booth-recoded |
| prod_o | output | 2N | Signed product |

## Verification
A wrong recoder entry or selector only corrupts products whose multiplier contains that window pattern. The error then appears at the output for exactly those operand pairs, in the same cycle in combinational mode or one clock later in registered mode. A missing +1 injection or a wrong sign extension usually shows up only for negative digits or negative multiplicands, and is off by a multiple of 8^i. For this reason, a small seven-bit configuration is swept over every operand pair. The sixteen-bit configuration is driven with repeated 5/6/7 group patterns, extreme values and random pairs.

// File: rtl/booth8_pkg.sv
package booth8_pkg;

    typedef enum logic [2:0] {
        MUL_ZERO  = 3'd0,
        MUL_ONE   = 3'd1,
        MUL_TWO   = 3'd2,
        MUL_THREE = 3'd3,
        MUL_FOUR  = 3'd4
    } mult_sel_e;

    typedef struct packed {
        logic      neg;
        mult_sel_e sel;
    } booth_digit_t;

    // Signed numeric value of a recoded digit, range -4..+4
    function automatic logic signed [3:0] digit_value(booth_digit_t d);
        logic signed [3:0] mag;
        mag = $signed({1'b0, d.sel});
        return d.neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/booth8_recoder.sv
module booth8_recoder
    import booth8_pkg::*;
(
    input  logic [3:0]   win_i,
    output booth_digit_t digit_o
);

    always_comb begin
        unique case (win_i)
            4'b0000: digit_o = '{neg: 1'b0, sel: MUL_ZERO};
            4'b0001: digit_o = '{neg: 1'b0, sel: MUL_ONE};
            4'b0010: digit_o = '{neg: 1'b0, sel: MUL_ONE};
            4'b0011: digit_o = '{neg: 1'b0, sel: MUL_TWO};
            4'b0100: digit_o = '{neg: 1'b0, sel: MUL_TWO};
            4'b0101: digit_o = '{neg: 1'b0, sel: MUL_THREE};
            4'b0110: digit_o = '{neg: 1'b0, sel: MUL_THREE};
            4'b0111: digit_o = '{neg: 1'b0, sel: MUL_FOUR};
            4'b1000: digit_o = '{neg: 1'b1, sel: MUL_FOUR};
            4'b1001: digit_o = '{neg: 1'b1, sel: MUL_THREE};
            4'b1010: digit_o = '{neg: 1'b1, sel: MUL_THREE};
            4'b1011: digit_o = '{neg: 1'b1, sel: MUL_TWO};
            4'b1100: digit_o = '{neg: 1'b1, sel: MUL_TWO};
            4'b1101: digit_o = '{neg: 1'b1, sel: MUL_ONE};
            4'b1110: digit_o = '{neg: 1'b1, sel: MUL_ONE};
            default: digit_o = '{neg: 1'b0, sel: MUL_ZERO};
        endcase
    end

    // R3: a zero digit never carries a negative sign
    always_comb begin
        if (digit_o.sel == MUL_ZERO) begin
            p_zero_positive_r3: assert (digit_o.neg == 1'b0)
                else $error("zero digit marked negative for window %b", win_i);
        end
    end

endmodule

// File: rtl/booth8_ppgen.sv
module booth8_ppgen
    import booth8_pkg::*;
#(
    parameter int W     = 32,
    parameter int SHIFT = 0
) (
    input  logic [W-1:0] m1_i,
    input  logic [W-1:0] m2_i,
    input  logic [W-1:0] m3_i,
    input  logic [W-1:0] m4_i,
    input  booth_digit_t digit_i,
    output logic [W-1:0] pp_o
);

    logic [W-1:0] mag_w;
    logic [W-1:0] cond_w;

    always_comb begin
        unique case (digit_i.sel)
            MUL_ONE:   mag_w = m1_i;
            MUL_TWO:   mag_w = m2_i;
            MUL_THREE: mag_w = m3_i;
            MUL_FOUR:  mag_w = m4_i;
            default:   mag_w = '0;
        endcase
        cond_w = digit_i.neg ? ~mag_w : mag_w;
        pp_o   = cond_w << SHIFT;
    end

    // R5: a zero digit contributes nothing to the sum
    always_comb begin
        if (digit_i.sel == MUL_ZERO && !digit_i.neg) begin
            p_zero_pp_r5: assert (pp_o == '0)
                else $error("nonzero partial product for zero digit");
        end
    end

endmodule

// File: rtl/booth8_sum_tree.sv
module booth8_sum_tree #(
    parameter int W   = 32,
    parameter int NUM = 7
) (
    input  logic [NUM*W-1:0] ops_i,
    output logic [W-1:0]     sum_o
);

    localparam int LV = (NUM > 1) ? $clog2(NUM) : 1;
    localparam int P  = 1 << LV;

    for (genvar l = 0; l <= LV; l++) begin : g_lvl
        localparam int CNT = P >> l;
        logic [W-1:0] s [CNT];
        for (genvar k = 0; k < CNT; k++) begin : g_node
            if (l == 0) begin : g_leaf
                if (k < NUM) begin : g_op
                    assign s[k] = ops_i[k*W +: W];
                end else begin : g_pad
                    assign s[k] = '0;
                end
            end else begin : g_add
                assign s[k] = g_lvl[l-1].s[2*k] + g_lvl[l-1].s[2*k+1];
            end
        end
    end

    assign sum_o = g_lvl[LV].s[0];

endmodule

// File: rtl/booth8_mul.sv
module booth8_mul
    import booth8_pkg::*;
#(
    parameter int N          = 16,
    parameter bit OUT_REG_EN = 1'b1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [N-1:0]   mcd_i,
    input  logic [N-1:0]   mlr_i,
    output logic [2*N-1:0] prod_o
);

    localparam int W  = 2 * N;
    localparam int G  = (N + 2) / 3;
    localparam int XW = 3 * G;
    localparam int NT = G + 1;

    // Multiplier sign-extended to full groups
    logic [XW-1:0] mlr_ext_w;
    if (XW > N) begin : g_mext
        assign mlr_ext_w = {{(XW-N){mlr_i[N-1]}}, mlr_i};
    end else begin : g_mnoext
        assign mlr_ext_w = mlr_i;
    end

    // Multiples of the multiplicand at product width
    logic [W-1:0] m1_w, m2_w, m3_w, m4_w;
    assign m1_w = {{N{mcd_i[N-1]}}, mcd_i};
    assign m2_w = m1_w << 1;
    assign m4_w = m1_w << 2;
    assign m3_w = m2_w + m1_w;   // the single pre-adder

    booth_digit_t     digit_w [G];
    logic [NT*W-1:0]  ops_w;
    logic [W-1:0]     corr_w;
    logic [W-1:0]     sum_w;

    for (genvar i = 0; i < G; i++) begin : g_grp
        logic [3:0] win;
        if (i == 0) begin : g_first
            assign win = {mlr_ext_w[2:0], 1'b0};
        end else begin : g_rest
            assign win = mlr_ext_w[3*i+2 : 3*i-1];
        end

        booth8_recoder u_rec (
            .win_i   (win),
            .digit_o (digit_w[i])
        );

        booth8_ppgen #(
            .W     (W),
            .SHIFT (3 * i)
        ) u_pp (
            .m1_i    (m1_w),
            .m2_i    (m2_w),
            .m3_i    (m3_w),
            .m4_i    (m4_w),
            .digit_i (digit_w[i]),
            .pp_o    (ops_w[i*W +: W])
        );
    end

    // +1 injections for negated digits, one per group at bit 3i
    always_comb begin
        corr_w = '0;
        for (int i = 0; i < G; i++) begin
            corr_w[3*i] = digit_w[i].neg;
        end
    end
    assign ops_w[G*W +: W] = corr_w;

    booth8_sum_tree #(
        .W   (W),
        .NUM (NT)
    ) u_tree (
        .ops_i (ops_w),
        .sum_o (sum_w)
    );

    if (OUT_REG_EN) begin : g_oreg
        logic [W-1:0] prod_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prod_q <= '0;
            else         prod_q <= sum_w;
        end
        assign prod_o = prod_q;

        logic signed [W-1:0] ref_w;
        assign ref_w = $signed({{N{mcd_i[N-1]}}, mcd_i}) * $signed({{N{mlr_i[N-1]}}, mlr_i});

        // R1 / R8: registered output equals last sampled signed product
        p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) |-> (prod_o == $past(ref_w)))
            else $error("registered product mismatch");
    end else begin : g_comb
        assign prod_o = sum_w;
    end

    // R2: weighted digit sum reproduces the sign-extended multiplier
    always_comb begin
        logic signed [XW+2:0] acc;
        logic signed [XW+2:0] term;
        logic signed [XW+2:0] want;
        acc  = '0;
        for (int i = 0; i < G; i++) begin
            term = digit_value(digit_w[i]);
            acc  = acc + (term <<< (3 * i));
        end
        want = $signed(mlr_ext_w);
        p_recode_sum_r2: assert (acc == want)
            else $error("digit sum %0d differs from multiplier %0d", acc, want);
    end

    // R4: pre-adder output is three times the multiplicand
    always_comb begin
        p_triple_r4: assert (m3_w == W'(3 * $signed(m1_w)))
            else $error("triple multiple wrong");
    end

endmodule

// File: tb/booth8_mul_tb.sv
module booth8_mul_tb_top;

    localparam int NB = 16;
    localparam int NS = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB-1:0]     a_big = '0, b_big = '0;
    logic [2*NB-1:0]   p_big;
    logic [NS-1:0]     a_sm = '0, b_sm = '0;
    logic [2*NS-1:0]   p_sm;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    booth8_mul #(.N(NB), .OUT_REG_EN(1'b1)) dut_i (
        .clk_i (clk), .rst_ni (rst_n),
        .mcd_i (a_big), .mlr_i (b_big), .prod_o (p_big)
    );

    booth8_mul #(.N(NS), .OUT_REG_EN(1'b0)) dut_small_i (
        .clk_i (clk), .rst_ni (rst_n),
        .mcd_i (a_sm), .mlr_i (b_sm), .prod_o (p_sm)
    );

    function automatic logic [2*NB-1:0] exp_big(logic [NB-1:0] a, logic [NB-1:0] b);
        longint pa, pb, pr;
        pa = longint'($signed(a));
        pb = longint'($signed(b));
        pr = pa * pb;
        return pr[2*NB-1:0];
    endfunction

    function automatic logic [2*NS-1:0] exp_sm(logic [NS-1:0] a, logic [NS-1:0] b);
        longint pa, pb, pr;
        pa = longint'($signed(a));
        pb = longint'($signed(b));
        pr = pa * pb;
        return pr[2*NS-1:0];
    endfunction

    task automatic check_big(input logic [NB-1:0] a, input logic [NB-1:0] b, input string req);
        logic [2*NB-1:0] e;
        @(negedge clk);
        a_big = a; b_big = b;
        e = exp_big(a, b);
        @(negedge clk);
        checks++;
        if (p_big !== e) begin
            fails++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, p_big, e);
        end
    endtask

    initial begin
        // Reset state (R8)
        a_big = 16'h1234; b_big = 16'h0F0F;
        repeat (3) @(negedge clk);
        checks++;
        if (p_big !== '0) begin
            fails++;
            $display("FAIL R8 reset actual=%h expected=0", p_big);
        end
        rst_n = 1'b1;

        // R8: one edge of latency, old value before, new value after
        @(negedge clk);
        a_big = 16'h0003; b_big = 16'h0005;
        #2;
        checks++;
        if (p_big !== exp_big(16'h1234, 16'h0F0F)) begin
            fails++;
            $display("FAIL R8 latency actual=%h expected=%h", p_big, exp_big(16'h1234, 16'h0F0F));
        end
        @(negedge clk);
        checks++;
        if (p_big !== 32'd15) begin
            fails++;
            $display("FAIL R8 capture actual=%h expected=%h", p_big, 32'd15);
        end

        // R7: extreme corners
        check_big(16'h8000, 16'h8000, "R7");
        check_big(16'hFFFF, 16'hFFFF, "R1");
        check_big(16'h7FFF, 16'h7FFF, "R1");
        check_big(16'h7FFF, 16'h8000, "R1");
        check_big(16'h8000, 16'hFFFF, "R1");
        // R6: zero operands
        check_big(16'h0000, 16'h8000, "R6");
        check_big(16'hABCD, 16'h0000, "R6");
        check_big(16'h0000, 16'h0000, "R6");
        // R3 / R5: groups of value 5, 6, 7 everywhere (negative digits, carries)
        check_big(16'h1357, 16'b0101101101101101, "R3");
        check_big(16'hC001, 16'b1110110110110110, "R3");
        check_big(16'h8001, 16'b1111111111111111, "R5");
        check_big(16'h7FFF, 16'b0111111111111111, "R5");
        // R2: top window needs multiplier sign extension
        check_big(16'h0101, 16'b1000000000000000, "R2");
        check_big(16'hFFFE, 16'b0100000000000000, "R2");
        // R4: each multiple selected across operand signs
        for (int k = 0; k < 8; k++) begin
            check_big(16'h5A5A ^ 16'(k * 16'h1111), 16'(k * 16'h0249), "R4");
        end
        // R1: random pairs
        for (int k = 0; k < 300; k++) begin
            check_big(16'($urandom), 16'($urandom), "R1");
        end

        // R9 / R1: exhaustive sweep of the combinational seven-bit variant
        for (int x = 0; x < (1 << NS); x++) begin
            for (int y = 0; y < (1 << NS); y++) begin
                a_sm = NS'(x); b_sm = NS'(y);
                #1;
                checks++;
                if (p_sm !== exp_sm(NS'(x), NS'(y))) begin
                    fails++;
                    $display("FAIL R9 a=%h b=%h actual=%h expected=%h",
                             a_sm, b_sm, p_sm, exp_sm(NS'(x), NS'(y)));
                end
            end
        end

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule